// File: doc/BRIEF.md
# Symbol history display buffer

This block builds the character image for a two-row, sixteen-column text display. The display watches a stream of 4-bit symbols and an 8-bit match count. The top row puts the symbol currently present on the input in the rightmost column as a lowercase letter, and it does so whether or not the valid strobe is high. To the left of that column are one blank column and then the fourteen most recently accepted symbols. The newest of those sits nearest the blank column. The bottom row shows the count as uppercase hexadecimal, right-justified, and every other position on that row holds a space.

Every accepted symbol shifts the history one place to the left. The oldest entry drops off and the new one enters at the right end. The display driver reads the image one character at a time through a combinational row/column port, or takes the whole image from two flat row vectors. Display controller timing and the logic that produces the count belong elsewhere.

Top module: `sym_history_display`

## Requirements
- R1: Top-row column 15 always equals 0x61 + sym_i, so code 0 shows 'a' and code 15 shows 'p'. It follows sym_i combinationally, during reset and with valid_i low or high.
- R2: Top-row column 14 is always ASCII space (0x20).
- R3: On each rising clock edge with valid_i high, top-row columns 0..12 take the previous contents of columns 1..13. Column 13 becomes 0x61 + the sym_i sampled at that edge.
- R4: On an edge with valid_i low, top-row columns 0..13 keep their values, however sym_i changes.
- R5: When rst_ni is low (asynchronous, active low), top-row columns 0..13 become 0x20.
- R6: Bottom-row columns 0..13 are 0x20. Column 14 is the hex digit of count_i[7:4] and column 15 is the hex digit of count_i[3:0]. Digits 0-9 are 0x30-0x39 and A-F are 0x41-0x46. The row follows count_i combinationally.
- R7: rd_char_o combinationally returns the character at column rd_col_i of the row picked by rd_row_i, where 0 selects the top row and 1 the bottom row.
- R8: In top_row_o and bot_row_o, column c occupies bits [8c+7:8c]. Column 0 is the leftmost column.
- R9: After more than 14 accepted symbols, columns 0..13 hold exactly the last 14 of them, oldest at column 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Accept sym_i into the history this cycle |
| sym_i | input | 4 | Current symbol code |
| count_i | input | 8 | Count shown on the bottom row |
| rd_row_i | input | 1 | Read row select (0 top, 1 bottom) |
| rd_col_i | input | 4 | Read column index, 0 leftmost |
| rd_char_o | output | 8 | Character code at the selected position |
| top_row_o | output | 128 | Flat top-row image |
| bot_row_o | output | 128 | Flat bottom-row image |

## Verification
The bench walks sym_i through all sixteen codes with valid_i low. It checks that the live column follows each code while the history does not move, which catches a design that gates the live column with valid or leaks the live symbol into the history. It pushes more than fourteen symbols and compares every column, which exposes a history that is too short, a shift in the wrong direction, an off-by-one entry point, or a missing blank column. Count values around the 9/A boundary and at 0x00 and 0xFF catch lowercase digits, swapped nibbles and bad digit offsets. A full sweep of the read port against the flat rows catches a swapped row select or a reversed column order.

// File: rtl/symdisp_pkg.sv
package symdisp_pkg;
  localparam int unsigned SYM_W = 4;
  localparam logic [7:0] CH_SPACE = 8'h20;

  function automatic logic [7:0] sym_to_ascii(input logic [SYM_W-1:0] s);
    return 8'h61 + {{(8-SYM_W){1'b0}}, s};
  endfunction

  function automatic logic [7:0] nib_to_hex(input logic [3:0] n);
    if (n < 4'd10) return 8'h30 + {4'h0, n};
    else           return 8'h37 + {4'h0, n};
  endfunction
endpackage

// File: rtl/sym_hist_shift.sv
module sym_hist_shift
  import symdisp_pkg::*;
#(
  parameter int unsigned DEPTH = 14
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   push_i,
  input  logic [SYM_W-1:0]       sym_i,
  output logic [DEPTH-1:0]       occ_o,
  output logic [DEPTH*SYM_W-1:0] code_o
);
  // entry DEPTH-1 is newest; entry 0 is oldest
  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic             nxt_occ;
    logic [SYM_W-1:0] nxt_code;
    if (i == DEPTH - 1) begin : g_head
      assign nxt_occ  = 1'b1;
      assign nxt_code = sym_i;
    end else begin : g_body
      assign nxt_occ  = occ_o[i+1];
      assign nxt_code = code_o[(i+1)*SYM_W +: SYM_W];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        occ_o[i]                  <= 1'b0;
        code_o[i*SYM_W +: SYM_W]  <= '0;
      end else if (push_i) begin
        occ_o[i]                  <= nxt_occ;
        code_o[i*SYM_W +: SYM_W]  <= nxt_code;
      end
    end
  end
endmodule

// File: rtl/top_row_fmt.sv
module top_row_fmt
  import symdisp_pkg::*;
#(
  parameter int unsigned COLS  = 16,
  parameter int unsigned DEPTH = COLS - 2
) (
  input  logic [DEPTH-1:0]       occ_i,
  input  logic [DEPTH*SYM_W-1:0] code_i,
  input  logic [SYM_W-1:0]       live_i,
  output logic [8*COLS-1:0]      row_o
);
  for (genvar c = 0; c < COLS; c++) begin : g_col
    if (c < DEPTH) begin : g_hist
      assign row_o[8*c +: 8] = occ_i[c] ? sym_to_ascii(code_i[c*SYM_W +: SYM_W]) : CH_SPACE;
    end else if (c == COLS - 1) begin : g_live
      assign row_o[8*c +: 8] = sym_to_ascii(live_i);
    end else begin : g_gap
      assign row_o[8*c +: 8] = CH_SPACE;
    end
  end
endmodule

// File: rtl/hex_row_fmt.sv
module hex_row_fmt
  import symdisp_pkg::*;
#(
  parameter int unsigned COLS  = 16,
  parameter int unsigned CNT_W = 8
) (
  input  logic [CNT_W-1:0]  count_i,
  output logic [8*COLS-1:0] row_o
);
  localparam int unsigned DIGITS = CNT_W / 4;

  for (genvar c = 0; c < COLS; c++) begin : g_col
    if (c >= COLS - DIGITS) begin : g_dig
      localparam int unsigned D = COLS - 1 - c;  // 0 = least significant nibble
      assign row_o[8*c +: 8] = nib_to_hex(count_i[4*D +: 4]);
    end else begin : g_pad
      assign row_o[8*c +: 8] = CH_SPACE;
    end
  end
endmodule

// File: rtl/row_read_mux.sv
module row_read_mux #(
  parameter int unsigned COLS  = 16,
  parameter int unsigned COL_W = $clog2(COLS)
) (
  input  logic [8*COLS-1:0] top_i,
  input  logic [8*COLS-1:0] bot_i,
  input  logic              row_i,
  input  logic [COL_W-1:0]  col_i,
  output logic [7:0]        char_o
);
  logic [8*COLS-1:0] sel_row;
  assign sel_row = row_i ? bot_i : top_i;
  assign char_o  = sel_row[{col_i, 3'b000} +: 8];
endmodule

// File: rtl/sym_history_display.sv
module sym_history_display
  import symdisp_pkg::*;
#(
  parameter int unsigned COLS  = 16,
  parameter int unsigned CNT_W = 8,
  localparam int unsigned DEPTH = COLS - 2,
  localparam int unsigned COL_W = $clog2(COLS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [SYM_W-1:0]  sym_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              rd_row_i,
  input  logic [COL_W-1:0]  rd_col_i,
  output logic [7:0]        rd_char_o,
  output logic [8*COLS-1:0] top_row_o,
  output logic [8*COLS-1:0] bot_row_o
);
  logic [DEPTH-1:0]       hist_occ;
  logic [DEPTH*SYM_W-1:0] hist_code;

  sym_hist_shift #(.DEPTH(DEPTH)) u_hist (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (valid_i),
    .sym_i  (sym_i),
    .occ_o  (hist_occ),
    .code_o (hist_code)
  );

  top_row_fmt #(.COLS(COLS), .DEPTH(DEPTH)) u_top (
    .occ_i  (hist_occ),
    .code_i (hist_code),
    .live_i (sym_i),
    .row_o  (top_row_o)
  );

  hex_row_fmt #(.COLS(COLS), .CNT_W(CNT_W)) u_bot (
    .count_i (count_i),
    .row_o   (bot_row_o)
  );

  row_read_mux #(.COLS(COLS), .COL_W(COL_W)) u_rd (
    .top_i  (top_row_o),
    .bot_i  (bot_row_o),
    .row_i  (rd_row_i),
    .col_i  (rd_col_i),
    .char_o (rd_char_o)
  );
endmodule

// File: rtl/symhist_chk.sv
module symhist_chk
  import symdisp_pkg::*;
#(
  parameter int unsigned COLS  = 16,
  parameter int unsigned CNT_W = 8,
  parameter int unsigned COL_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [SYM_W-1:0]  sym_i,
  input logic [CNT_W-1:0]  count_i,
  input logic              rd_row_i,
  input logic [COL_W-1:0]  rd_col_i,
  input logic [7:0]        rd_char_o,
  input logic [8*COLS-1:0] top_row_o,
  input logic [8*COLS-1:0] bot_row_o
);
  localparam int unsigned DEPTH = COLS - 2;
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(COLS - 1);

  a_r1_live_col: assert property (@(posedge clk_i) disable iff (!rst_ni)
    top_row_o[8*(COLS-1) +: 8] == 8'h61 + {4'h0, sym_i});

  a_r2_gap_blank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    top_row_o[8*(COLS-2) +: 8] == CH_SPACE);

  a_r3_newest_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> top_row_o[8*(DEPTH-1) +: 8] == 8'h61 + {4'h0, $past(sym_i)});

  for (genvar k = 0; k < DEPTH - 1; k++) begin : g_shift
    a_r3_shift_left: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> top_row_o[8*k +: 8] == $past(top_row_o[8*(k+1) +: 8]));
  end

  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(top_row_o[8*DEPTH-1:0]));

  for (genvar c = 0; c < DEPTH; c++) begin : g_pad
    a_r6_bot_pad: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bot_row_o[8*c +: 8] == CH_SPACE);
  end

  a_r6_low_digit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bot_row_o[8*(COLS-1) +: 8] == nib_to_hex(count_i[3:0]));

  a_r7_read_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_row_i && rd_col_i == LAST_COL) |-> rd_char_o == 8'h61 + {4'h0, sym_i});

  a_r7_read_bot_pad: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_row_i && rd_col_i == '0) |-> rd_char_o == CH_SPACE);
endmodule

bind sym_history_display symhist_chk #(.COLS(COLS), .CNT_W(CNT_W), .COL_W(COL_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .sym_i     (sym_i),
  .count_i   (count_i),
  .rd_row_i  (rd_row_i),
  .rd_col_i  (rd_col_i),
  .rd_char_o (rd_char_o),
  .top_row_o (top_row_o),
  .bot_row_o (bot_row_o)
);

// File: tb/sim_sym_history_display.sv
`timescale 1ns/1ps
module sim_sym_history_display;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [3:0]   sym_i = 4'h0;
  logic [7:0]   count_i = 8'h00;
  logic         rd_row_i = 1'b0;
  logic [3:0]   rd_col_i = 4'h0;
  logic [7:0]   rd_char_o;
  logic [127:0] top_row_o;
  logic [127:0] bot_row_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [7:0] exp_hist [14];

  always #10 clk_i = ~clk_i;

  sym_history_display u0 (.*);

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] letter(input logic [3:0] s);
    return 8'h61 + {4'h0, s};
  endfunction

  function automatic logic [7:0] hexch(input logic [3:0] n);
    return (n < 4'd10) ? 8'h30 + {4'h0, n} : 8'h41 + {4'h0, n} - 8'd10;
  endfunction

  function automatic logic [127:0] exp_top();
    logic [127:0] v;
    for (int c = 0; c < 14; c++) v[8*c +: 8] = exp_hist[c];
    v[8*14 +: 8] = 8'h20;
    v[8*15 +: 8] = letter(sym_i);
    return v;
  endfunction

  function automatic logic [127:0] exp_bot();
    logic [127:0] v = {16{8'h20}};
    v[8*14 +: 8] = hexch(count_i[7:4]);
    v[8*15 +: 8] = hexch(count_i[3:0]);
    return v;
  endfunction

  task automatic clear_model();
    for (int k = 0; k < 14; k++) exp_hist[k] = 8'h20;
  endtask

  task automatic push(input logic [3:0] s);
    @(negedge clk_i);
    valid_i = 1'b1;
    sym_i = s;
    @(negedge clk_i);
    valid_i = 1'b0;
    for (int k = 0; k < 13; k++) exp_hist[k] = exp_hist[k+1];
    exp_hist[13] = letter(s);
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    clear_model();
    sym_i = 4'h5;
    #2;
    chk("R5 reset history blank", top_row_o, exp_top());
    chk("R2 gap blank in reset", {120'h0, top_row_o[119:112]}, {120'h0, 8'h20});
    chk("R1 live during reset", {120'h0, top_row_o[127:120]}, {120'h0, 8'h66});
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic t_live();
    for (int s = 0; s < 16; s++) begin
      @(negedge clk_i);
      sym_i = 4'(s);
      #2;
      chk("R1 live column", {120'h0, top_row_o[127:120]}, {120'h0, 8'h61 + 8'(s)});
    end
    @(negedge clk_i);
    chk("R4 live symbols not stored", top_row_o, exp_top());
  endtask

  task automatic t_push_seq();
    push(4'h0); push(4'h1); push(4'h1); push(4'h1); push(4'h3);
    chk("R3 shifted sequence", top_row_o, exp_top());
    chk("R8 newest at bits 111:104", {120'h0, top_row_o[111:104]}, {120'h0, 8'h64});
    chk("R8 column 9 byte", {120'h0, top_row_o[79:72]}, {120'h0, 8'h61});
  endtask

  task automatic t_wrap();
    for (int i = 0; i < 20; i++) push(4'((i * 7 + 2) % 16));
    chk("R9 last fourteen kept", top_row_o, exp_top());
    push(4'hF);
    chk("R3 oldest dropped", top_row_o, exp_top());
  endtask

  task automatic t_hold();
    logic [127:0] snap;
    snap = top_row_o;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk_i);
      sym_i = 4'(i + 9);
    end
    @(negedge clk_i);
    chk("R4 history hold", {16'h0, top_row_o[111:0]}, {16'h0, snap[111:0]});
    chk("R4 model agrees", top_row_o, exp_top());
  endtask

  task automatic t_count();
    logic [7:0] vals [6] = '{8'h00, 8'h09, 8'h0A, 8'h3A, 8'h9F, 8'hFF};
    for (int i = 0; i < 6; i++) begin
      @(negedge clk_i);
      count_i = vals[i];
      #2;
      chk("R6 bottom row", bot_row_o, exp_bot());
    end
  endtask

  task automatic t_read();
    logic [127:0] rt, rb;
    rt = exp_top();
    rb = exp_bot();
    for (int r = 0; r < 2; r++) begin
      for (int c = 0; c < 16; c++) begin
        @(negedge clk_i);
        rd_row_i = r[0];
        rd_col_i = 4'(c);
        #2;
        chk(r == 0 ? "R7 read top" : "R7 read bottom", {120'h0, rd_char_o},
            {120'h0, r == 0 ? rt[8*c +: 8] : rb[8*c +: 8]});
      end
    end
  endtask

  task automatic t_reset_mid();
    @(negedge clk_i);
    rst_ni = 1'b0;
    clear_model();
    #2;
    chk("R5 reset clears history", top_row_o, exp_top());
    @(negedge clk_i);
    rst_ni = 1'b1;
    push(4'h2);
    chk("R3 first push after reset", top_row_o, exp_top());
  endtask

  initial begin
    clear_model();
    t_reset();
    t_live();
    t_push_seq();
    t_wrap();
    t_hold();
    t_count();
    t_read();
    t_reset_mid();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule